// File: doc/BRIEF.md
# Single-Slope Column Converter Counter with In-Place Double Sampling

This block holds the digital side of one column of a single-slope converter. An analog ramp, driven by a shared generator, is compared against the pixel level. The comparator output stays high while the ramp is still below the pixel voltage. The length of that high interval is a pulse width that the block turns into a count of fast counting-clock cycles. Each conversion makes two readings of the pixel. The first is a short window at the pixel's reset level and the second is a full window at its signal level.

Between the two readings a single up/down counter reverses direction. It counts downward while the reset level is measured and upward while the signal level is measured. Because it is never cleared between the two windows, the value left at the end is the signal count minus the reset count. This removes the pixel's fixed offset without a separate subtractor. The block tells the ramp generator when to step, reports which window is running, and hands back a signed result with a one-cycle completion pulse. It also raises a flag when the comparator never fell inside a window.

Top module: `ss_cds_adc`

## Requirements
- R1: While and right after reset, `phase` is 0 (idle), and `ramp_step`, `done`, `saturated` and `result` are all 0.
- R2: A `start` pulse seen in idle opens the reset-level window. It lasts exactly 2^(RES_BITS-2) cycles with `phase` = 1 and `ramp_step` high.
- R3: The reset-level window is followed by a settling gap of GAP_CYC cycles with `phase` = 2 and `ramp_step` low. After that comes the signal-level window of exactly 2^RES_BITS cycles with `phase` = 3 and `ramp_step` high, and then the block returns to idle (`phase` = 0).
- R4: `cmp_in` passes through a two-flop synchronizer. Inside a window, one count is taken per cycle while the synchronized comparator is high, and counting stops for the rest of the window at its first low. If `cmp_in` is high when a window opens and falls just after the d-th window cycle (counting from 0), that window contributes min(d+2, window length) counts.
- R5: The counter is cleared only when a conversion starts. It counts down in the reset-level window and up in the signal-level window, and keeps its value through the gap. `result` is the two's-complement difference (signal count minus reset count), RES_BITS+2 bits wide.
- R6: `saturated` is 1 with a result when, in either window, the synchronized comparator stayed high for every cycle of that window (the count equals the window length).
- R7: `done` is high for exactly one cycle, in the cycle right after the last signal-window cycle. In that same cycle the new `result` and `saturated` are visible and `phase` is back to 0.
- R8: `result` and `saturated` change only in a cycle where `done` is high, and otherwise hold their last value.
- R9: A `start` pulse while a conversion is running is ignored. The running conversion keeps its timing and result, and exactly one `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request strobe, honoured only in idle |
| cmp_in | input | 1 | Raw comparator output, 1 while the ramp is below the pixel level |
| ramp_step | output | 1 | High while the ramp must advance (inside a counting window) |
| phase | output | 2 | 0 idle, 1 reset-level window, 2 gap, 3 signal-level window |
| result | output | RES_BITS+2 | Signed signal-minus-reset count |
| saturated | output | 1 | Some window ended without a comparator fall |
| done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The hardest case to reach is a comparator fall that lands exactly at a window boundary. Near it, the synchronizer latency decides whether a window counts one short of full or saturates. To get there, the stimulus watches `ramp_step` and `phase` at the ports and drops `cmp_in` on a chosen window cycle. It picks cycles two and three short of the window end in both windows, and it also uses a window in which the comparator never falls. A start pulse injected in the middle of the signal window checks that a busy conversion cannot be restarted.

// File: rtl/ss_adc_pkg.sv
package ss_adc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REF  = 2'd1,
    PH_GAP  = 2'd2,
    PH_SIG  = 2'd3
  } phase_e;

  // number of counting cycles in a window
  function automatic int unsigned window_cycles(input int unsigned bits, input bit full);
    return full ? (32'd1 << bits) : (32'd1 << (bits - 2));
  endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/phase_ctrl.sv
module phase_ctrl
  import ss_adc_pkg::*;
#(
  parameter int RES_BITS = 8,
  parameter int GAP_CYC  = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   arm,
  output logic   ramp_on,
  output logic   dir_up,
  output logic   win_last,
  output logic   conv_end
);
  localparam int CW = RES_BITS;
  localparam logic [CW-1:0] REF_LAST = CW'(window_cycles(RES_BITS, 1'b0) - 1);
  localparam logic [CW-1:0] SIG_LAST = CW'(window_cycles(RES_BITS, 1'b1) - 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);

  phase_e        ph_q;
  logic [CW-1:0] wcnt;
  logic          ref_end, gap_end;

  assign arm      = (ph_q == PH_IDLE) && start;
  assign ref_end  = (ph_q == PH_REF) && (wcnt == REF_LAST);
  assign gap_end  = (ph_q == PH_GAP) && (wcnt == GAP_LAST);
  assign conv_end = (ph_q == PH_SIG) && (wcnt == SIG_LAST);
  assign win_last = ref_end || conv_end;
  assign ramp_on  = (ph_q == PH_REF) || (ph_q == PH_SIG);
  assign dir_up   = (ph_q == PH_SIG);
  assign phase    = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      wcnt <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start) begin ph_q <= PH_REF; wcnt <= '0; end
        PH_REF:  if (ref_end) begin ph_q <= PH_GAP; wcnt <= '0; end
                 else wcnt <= wcnt + 1'b1;
        PH_GAP:  if (gap_end) begin ph_q <= PH_SIG; wcnt <= '0; end
                 else wcnt <= wcnt + 1'b1;
        PH_SIG:  if (conv_end) begin ph_q <= PH_IDLE; wcnt <= '0; end
                 else wcnt <= wcnt + 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cds_counter.sv
module cds_counter #(
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic                active,
  input  logic                dir_up,
  input  logic                cmp_s,
  input  logic                win_last,
  input  logic                conv_end,
  output logic                cnt_en,
  output logic [RES_BITS+1:0] result,
  output logic                saturated,
  output logic                done
);
  localparam int RW = RES_BITS + 2;

  function automatic logic [RW-1:0] step_cnt(input logic [RW-1:0] c, input logic up);
    return up ? c + RW'(1) : c - RW'(1);
  endfunction

  logic [RW-1:0] cnt, cnt_nxt;
  logic          tripped, full_win, sat_acc;

  assign cnt_en   = active && cmp_s && !tripped;
  assign cnt_nxt  = cnt_en ? step_cnt(cnt, dir_up) : cnt;
  assign full_win = win_last && cmp_s && !tripped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      tripped   <= 1'b0;
      sat_acc   <= 1'b0;
      result    <= '0;
      saturated <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= conv_end;
      if (arm) begin
        cnt     <= '0;
        tripped <= 1'b0;
        sat_acc <= 1'b0;
      end else begin
        cnt <= cnt_nxt;
        if (win_last)                tripped <= 1'b0;
        else if (active && !cmp_s)   tripped <= 1'b1;
        if (full_win) sat_acc <= 1'b1;
      end
      if (conv_end) begin
        result    <= cnt_nxt;
        saturated <= sat_acc || full_win;
      end
    end
  end
endmodule

// File: rtl/ss_cds_adc.sv
module ss_cds_adc
  import ss_adc_pkg::*;
#(
  parameter int RES_BITS    = 8,
  parameter int GAP_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cmp_in,
  output logic                ramp_step,
  output logic [1:0]          phase,
  output logic [RES_BITS+1:0] result,
  output logic                saturated,
  output logic                done
);
  phase_e ph;
  logic   arm, ramp_on, dir_up, win_last, conv_end, cmp_s, cnt_en;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_in), .q(cmp_s)
  );

  phase_ctrl #(.RES_BITS(RES_BITS), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .phase(ph), .arm(arm),
    .ramp_on(ramp_on), .dir_up(dir_up), .win_last(win_last), .conv_end(conv_end)
  );

  cds_counter #(.RES_BITS(RES_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .arm(arm), .active(ramp_on), .dir_up(dir_up),
    .cmp_s(cmp_s), .win_last(win_last), .conv_end(conv_end), .cnt_en(cnt_en),
    .result(result), .saturated(saturated), .done(done)
  );

  assign ramp_step = ramp_on;
  assign phase     = ph;
endmodule

// File: rtl/ss_cds_adc_chk.sv
module ss_cds_adc_chk #(
  parameter int RES_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ramp_step,
  input logic [1:0]          phase,
  input logic [RES_BITS+1:0] result,
  input logic                saturated,
  input logic                done,
  input logic                cnt_en,
  input logic                win_last
);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_sig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(phase) == 2'd3 && phase == 2'd0));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(result) || !$stable(saturated)) |-> done);

  assert_ramp_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_step |-> (phase == 2'd1 || phase == 2'd3));

  assert_count_needs_ramp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |-> ramp_step);

  assert_gap_after_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && $past(phase) != 2'd2) |-> $past(phase) == 2'd1);

  assert_sig_after_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && $past(phase) != 2'd3) |-> $past(phase) == 2'd2);

  assert_win_end_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> !ramp_step);
endmodule

bind ss_cds_adc ss_cds_adc_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ramp_step(ramp_step), .phase(phase),
  .result(result), .saturated(saturated), .done(done),
  .cnt_en(cnt_en), .win_last(win_last)
);

// File: tb/ss_cds_adc_tb.sv
module ss_cds_adc_tb;
  localparam int N   = 8;
  localparam int GAP = 4;
  localparam int WR  = 1 << (N - 2);
  localparam int WS  = 1 << N;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp_in = 1'b0;
  logic ramp_step, saturated, done;
  logic [1:0] phase;
  logic [N+1:0] result;

  int total = 0, bad = 0;
  int exp_res_q[$];
  bit exp_sat_q[$];
  bit done_prev = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ss_cds_adc #(.RES_BITS(N), .GAP_CYC(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
    .ramp_step(ramp_step), .phase(phase), .result(result),
    .saturated(saturated), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int win_count(input int d, input int w);
    return (d + 2 < w) ? d + 2 : w;
  endfunction

  // monitor: pops the scoreboard on every completion pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && done_prev) check(1'b0, "R7 done longer than one cycle", 1, 0);
      if (done) begin
        if (exp_res_q.size() == 0) begin
          check(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          int er;
          bit es;
          er = exp_res_q.pop_front();
          es = exp_sat_q.pop_front();
          check(int'($signed(result)) == er, "R5 result", int'($signed(result)), er);
          check(saturated == es, "R6 saturated", int'(saturated), int'(es));
          check(phase == 2'd0, "R7 phase idle at done", int'(phase), 0);
        end
      end
      done_prev = done;
    end
  end

  // driver: one conversion, comparator falls after window cycle dr / ds
  task automatic convert(input int dr, input int ds, input bit poke);
    int cr, cs, k, rh, gh, sh, er;
    cr = win_count(dr, WR);
    cs = win_count(ds, WS);
    er = cs - cr;
    exp_res_q.push_back(er);
    exp_sat_q.push_back((cr == WR) || (cs == WS));
    cmp_in = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; rh = 0; gh = 0; sh = 0;
    while (phase != 2'd0) begin
      start = 1'b0;
      if (phase == 2'd1) begin
        if (ramp_step) begin
          if (k == dr) cmp_in = 1'b0;
          k++; rh++;
        end
      end else if (phase == 2'd2) begin
        cmp_in = 1'b1; k = 0; gh++;
      end else begin
        if (ramp_step) begin
          if (k == ds) cmp_in = 1'b0;
          k++; sh++;
          if (poke && k == 5) start = 1'b1;
        end
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(rh == WR, "R2 reset window length", rh, WR);
    check(gh == GAP, "R3 gap length", gh, GAP);
    check(sh == WS, "R3 signal window length", sh, WS);
    repeat (10) @(negedge clk);
    check(int'($signed(result)) == er, "R8 result held after done", int'($signed(result)), er);
    check(phase == 2'd0 && !done, "R9 no restart after conversion", int'(phase), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(phase == 2'd0 && !ramp_step && !done && !saturated && result == '0,
          "R1 state in reset", int'(phase), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(phase == 2'd0 && !ramp_step && !done && !saturated && result == '0,
          "R1 state after reset", int'(result), 0);

    convert(10, 100, 1'b0);   // R5 positive difference 90
    convert(50, 20, 1'b0);    // R5 negative difference -30
    convert(0, 0, 1'b0);      // R4 earliest fall, 2 counts each
    convert(61, 253, 1'b0);   // R4 one short of full in both windows, no R6
    convert(62, 254, 1'b0);   // R6 both windows full
    convert(500, 30, 1'b0);   // R6 reset window never falls
    convert(5, 400, 1'b0);    // R6 signal window never falls
    convert(20, 40, 1'b1);    // R9 start poked mid signal window

    check(exp_res_q.size() == 0, "R7 every conversion produced done",
          exp_res_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule